// File: doc/BRIEF.md
# Parallel Wilkinson Converter Digital Back End

This block is the digital half of a ramp-compare (Wilkinson) converter that turns all the stored samples of one channel into numbers in a single pass. A start pulse marks the moment the analog ramp begins. From that point a single shared counter, kept in Gray code so that only one bit toggles per step, walks through every code of the result width. Each stored sample has its own comparator and its own capture register. When a comparator output rises, that register takes the current counter code. All registers watch the same counter.

When the counter has covered the full range, any sample whose comparator never rose is given the full-scale code. The block then waits for the host to pull the results. Each read strobe returns one result, converted from Gray code to plain binary, in sample order from the first sample to the last. A done flag rises together with the final result. The analog ramp and the comparators lie outside this block. A multi-channel converter places one instance per channel, for example eight instances for 512 conversions in parallel.

Top module: `wadc_digitizer`

## Requirements
- R1: After reset, `done`, `dout_vld` and `dout` are all zero.
- R2: The counter is zero in the first conversion cycle, which is the cycle right after the cycle in which `start` is sampled high. A comparator that rises in that first conversion cycle yields result 0.
- R3: A comparator that first rises in conversion cycle k (k = 0 .. 4095) yields result k. The shared counter advances by exactly one Gray step per conversion cycle.
- R4: Only the first rise of a comparator after `start` is captured. Later rises in the same conversion leave its result unchanged.
- R5: A sample whose comparator never rises during conversion yields full scale, 4095.
- R6: A rise is a comparator bit that is 0 in one sampled cycle and 1 in the next, with the 1 sampled in a conversion cycle. A comparator that is already high when `start` is sampled, and stays high, yields 4095.
- R7: Results are presented in plain binary. Output bit j is the XOR of captured Gray bits j through 11.
- R8: In the readout phase, each `rd_stb` sampled high returns the next result on `dout`, with `dout_vld` high for one cycle in the following cycle. Results come out in sample order 0, 1, ..., 63.
- R9: `done` rises in the same cycle that the 64th result appears on `dout`. It stays high until the next `start`.
- R10: `rd_stb` has no effect outside the readout phase. No `dout_vld` follows it, and the readout position does not advance.
- R11: `start` restarts conversion from any phase. It clears `done` in the next cycle and discards all earlier captures.
- R12: Conversion lasts exactly 4096 cycles. A strobe sampled in the last conversion cycle is ignored, and a strobe in the next cycle returns result 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle pulse marking the start of the ramp |
| fire | input | 64 | Comparator outputs, one bit per stored sample |
| rd_stb | input | 1 | Read strobe, one result per strobe |
| done | output | 1 | High after the last result has been presented |
| dout | output | 12 | Binary result of the current sample |
| dout_vld | output | 1 | One-cycle qualifier for `dout` |

## Verification
The assertions assume that `fire` and `rd_stb` are synchronous to `clk` and stable around the sampling edge. This stands in for comparators that have already been resynchronized. The bench therefore changes every input only on the falling edge. Comparator bits are held low before `start` unless a case deliberately holds one high to exercise R6. Strobes are issued one at a time with an idle cycle between them, so each returned value can be tied to a single strobe.

// File: rtl/wadc_pkg.sv
// Shared types for the Wilkinson converter back end.
// Assumes: nothing beyond a single clock domain.
package wadc_pkg;

    // Operating phase of one converter channel.
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_CONV = 2'd1,
        PH_READ = 2'd2,
        PH_DONE = 2'd3
    } phase_t;

endpackage

// File: rtl/wadc_gray_ramp.sv
// Shared ramp counter. It keeps a binary count for the terminal test and a
// registered Gray copy that is fanned out to every capture register, so only
// one distributed bit toggles per step.
// Assumes: clear has priority over run; the count holds once it reaches max.
module wadc_gray_ramp #(
    parameter int CW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          run,
    output logic [CW-1:0] gray_o,
    output logic          last_o
);

    logic [CW-1:0] bin_q;
    logic [CW-1:0] bin_nx;
    logic [CW-1:0] gray_q;

    // Next binary count.
    always_comb bin_nx = bin_q + 1'b1;

    // Advance the binary count and its Gray image together.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            bin_q  <= '0;
            gray_q <= '0;
        end else if (run && !last_o) begin
            bin_q  <= bin_nx;
            gray_q <= bin_nx ^ (bin_nx >> 1);
        end
    end

    // Terminal count flag.
    always_comb last_o = &bin_q;

    assign gray_o = gray_q;

endmodule

// File: rtl/wadc_capture_bank.sv
// One capture register per stored sample. Each lane detects the first rising
// comparator edge during conversion and freezes the shared Gray code. A lane
// that is still empty on the terminal count takes the terminal (full-scale) code.
// Assumes: fire is synchronous to clk; gray is full scale when last is high.
module wadc_capture_bank #(
    parameter int NS = 64,
    parameter int CW = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             run,
    input  logic             last,
    input  logic [NS-1:0]    fire,
    input  logic [CW-1:0]    gray,
    output logic [NS*CW-1:0] codes_o,
    output logic [NS-1:0]    held_o
);

    for (genvar i = 0; i < NS; i++) begin : g_lane
        logic          fire_q;
        logic          held_q;
        logic [CW-1:0] code_q;
        logic          rise;

        // Previous comparator level, tracked in every phase.
        always_ff @(posedge clk) begin
            if (!rst_n) fire_q <= 1'b0;
            else        fire_q <= fire[i];
        end

        // Rising edge of this lane's comparator.
        always_comb rise = fire[i] & ~fire_q;

        // Freeze the code on the first rise or at terminal count.
        always_ff @(posedge clk) begin
            if (!rst_n || clear) begin
                held_q <= 1'b0;
                code_q <= '0;
            end else if (run && !held_q && (rise || last)) begin
                held_q <= 1'b1;
                code_q <= gray;
            end
        end

        assign codes_o[i*CW +: CW] = code_q;
        assign held_o[i]           = held_q;
    end

endmodule

// File: rtl/wadc_gray2bin.sv
// Combinational Gray-to-binary decoder: each binary bit is the parity of the
// Gray bits at and above its position.
// Assumes: nothing; purely combinational.
module wadc_gray2bin #(
    parameter int CW = 12
) (
    input  logic [CW-1:0] gray_i,
    output logic [CW-1:0] bin_o
);

    for (genvar j = 0; j < CW; j++) begin : g_bit
        assign bin_o[j] = ^gray_i[CW-1:j];
    end

endmodule

// File: rtl/wadc_readout.sv
// Serializer for the captured codes. Each accepted strobe selects the next
// lane in ascending order, decodes it to binary and registers it with a
// one-cycle valid.
// Assumes: en is high only in the readout phase; clear has priority.
module wadc_readout #(
    parameter int NS = 64,
    parameter int CW = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             en,
    input  logic             rd_stb,
    input  logic [NS*CW-1:0] codes,
    output logic [CW-1:0]    dout,
    output logic             dout_vld,
    output logic             last_o
);

    localparam int IW = (NS > 1) ? $clog2(NS) : 1;

    logic [IW-1:0] idx_q;
    logic [CW-1:0] sel_gray;
    logic [CW-1:0] sel_bin;
    logic          take;

    // Pick the lane at the current read position.
    always_comb sel_gray = codes[idx_q*CW +: CW];

    wadc_gray2bin #(.CW(CW)) u_dec (
        .gray_i (sel_gray),
        .bin_o  (sel_bin)
    );

    // Strobe accepted this cycle.
    always_comb take = en && rd_stb && !clear;

    // Final lane being taken.
    always_comb last_o = take && (idx_q == IW'(NS - 1));

    // Advance the read position and register the decoded result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q    <= '0;
            dout     <= '0;
            dout_vld <= 1'b0;
        end else if (clear) begin
            idx_q    <= '0;
            dout_vld <= 1'b0;
        end else if (take) begin
            idx_q    <= idx_q + 1'b1;
            dout     <= sel_bin;
            dout_vld <= 1'b1;
        end else begin
            dout_vld <= 1'b0;
        end
    end

endmodule

// File: rtl/wadc_digitizer.sv
// Top of one converter channel: phase control around the shared Gray ramp,
// the per-sample capture bank and the ordered readout.
// Assumes: start is a one-cycle pulse; fire and rd_stb are synchronous to clk.
module wadc_digitizer #(
    parameter int NUM_SAMPLES = 64,
    parameter int CODE_BITS   = 12
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic [NUM_SAMPLES-1:0] fire,
    input  logic                   rd_stb,
    output logic                   done,
    output logic [CODE_BITS-1:0]   dout,
    output logic                   dout_vld
);

    import wadc_pkg::*;

    localparam int FLAT_W = NUM_SAMPLES * CODE_BITS;

    phase_t                 phase_q;
    logic [CODE_BITS-1:0]   ramp_gray;
    logic                   ramp_last;
    logic                   run;
    logic [FLAT_W-1:0]      codes;
    logic [NUM_SAMPLES-1:0] held;
    logic                   rd_last;

    // Conversion is active except in the cycle that restarts it.
    always_comb run = (phase_q == PH_CONV) && !start;

    // Phase sequencing: start, convert, read, done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
        end else if (start) begin
            phase_q <= PH_CONV;
        end else begin
            case (phase_q)
                PH_CONV: if (ramp_last) phase_q <= PH_READ;
                PH_READ: if (rd_last)   phase_q <= PH_DONE;
                default: phase_q <= phase_q;
            endcase
        end
    end

    wadc_gray_ramp #(.CW(CODE_BITS)) u_ramp (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (start),
        .run    (run),
        .gray_o (ramp_gray),
        .last_o (ramp_last)
    );

    wadc_capture_bank #(.NS(NUM_SAMPLES), .CW(CODE_BITS)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (start),
        .run     (run),
        .last    (ramp_last),
        .fire    (fire),
        .gray    (ramp_gray),
        .codes_o (codes),
        .held_o  (held)
    );

    wadc_readout #(.NS(NUM_SAMPLES), .CW(CODE_BITS)) u_rd (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (start),
        .en       (phase_q == PH_READ),
        .rd_stb   (rd_stb),
        .codes    (codes),
        .dout     (dout),
        .dout_vld (dout_vld),
        .last_o   (rd_last)
    );

    // Completion flag follows the final phase.
    always_comb done = (phase_q == PH_DONE);

endmodule

// File: rtl/wadc_digitizer_chk.sv
// Property checker for wadc_digitizer, attached through bind.
// Assumes: inputs are synchronous to clk.
module wadc_digitizer_chk
    import wadc_pkg::*;
#(
    parameter int NS = 64,
    parameter int CW = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             rd_stb,
    input logic             done,
    input logic             dout_vld,
    input phase_t           phase,
    input logic [CW-1:0]    ramp_gray,
    input logic [NS-1:0]    held,
    input logic [NS*CW-1:0] codes
);

    // R3: one Gray bit changes per conversion step.
    a_r3_gray_one_step: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_CONV && $past(phase == PH_CONV) && !$past(start))
        |-> ($countones(ramp_gray ^ $past(ramp_gray)) == 1));

    // R5: every lane holds a code once readout begins.
    a_r5_all_held_in_read: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_READ) |-> (&held));

    // R9: done rises only together with a presented result.
    a_r9_done_with_result: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> dout_vld);

    // R10: results follow only strobes taken in the readout phase.
    a_r10_vld_only_in_read: assert property (@(posedge clk) disable iff (!rst_n)
        dout_vld |-> ($past(rd_stb) && $past(phase == PH_READ)));

    // R11: start clears done on the next cycle.
    a_r11_start_clears_done: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !done);

    // R4: a held lane keeps its code until the next start.
    for (genvar i = 0; i < NS; i++) begin : g_lane_chk
        a_r4_code_frozen: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(held[i]) && held[i]) |-> $stable(codes[i*CW +: CW]));
    end

endmodule

bind wadc_digitizer wadc_digitizer_chk #(.NS(NUM_SAMPLES), .CW(CODE_BITS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .rd_stb    (rd_stb),
    .done      (done),
    .dout_vld  (dout_vld),
    .phase     (phase_q),
    .ramp_gray (ramp_gray),
    .held      (held),
    .codes     (codes)
);

// File: tb/wadc_digitizer_tb.sv
`timescale 1ns/1ps
module wadc_digitizer_tb;

    localparam int NS   = 64;
    localparam int CW   = 12;
    localparam int FULL = (1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [NS-1:0] fire = '0;
    logic          rd_stb = 1'b0;
    logic          done;
    logic [CW-1:0] dout;
    logic          dout_vld;

    int total = 0;
    int bad   = 0;
    // First-rise cycle per lane: -1 never rises, -2 held high across start.
    int fire_at [NS];

    always #10 clk = ~clk;

    wadc_digitizer #(.NUM_SAMPLES(NS), .CODE_BITS(CW)) u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .fire     (fire),
        .rd_stb   (rd_stb),
        .done     (done),
        .dout     (dout),
        .dout_vld (dout_vld)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int expect_of(input int a);
        return (a >= 0) ? a : FULL;
    endfunction

    // Drive start, then 4096 conversion cycles with the fire schedule.
    task automatic run_conv(input bit late_strobe);
        @(negedge clk);
        for (int i = 0; i < NS; i++) fire[i] = (fire_at[i] == -2);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(done == 1'b0, "R11 done cleared by start", int'(done), 0);
        for (int c = 0; c <= FULL; c++) begin
            for (int i = 0; i < NS; i++) begin
                if (fire_at[i] == -2)      fire[i] = 1'b1;
                else if (fire_at[i] == -1) fire[i] = 1'b0;
                else fire[i] = (c == fire_at[i]) || (c >= fire_at[i] + 2);
            end
            rd_stb = late_strobe && (c == FULL);
            @(negedge clk);
        end
        if (late_strobe)
            chk(dout_vld == 1'b0, "R12 strobe in last conversion cycle ignored", int'(dout_vld), 0);
        rd_stb = 1'b0;
        fire = '0;
    endtask

    // Pull all results and compare with the schedule.
    task automatic read_all();
        for (int i = 0; i < NS; i++) begin
            int e;
            string tag;
            e = expect_of(fire_at[i]);
            if (fire_at[i] == 0)        tag = "R2";
            else if (fire_at[i] == -1)  tag = "R5";
            else if (fire_at[i] == -2)  tag = "R6";
            else if (fire_at[i] + 2 <= FULL) tag = "R4";
            else                        tag = "R3";
            rd_stb = 1'b1;
            @(negedge clk);
            rd_stb = 1'b0;
            chk(dout_vld == 1'b1, "R8 valid after strobe", int'(dout_vld), 1);
            chk(int'(dout) == e, tag, int'(dout), e);
            if (i == NS - 1) chk(done == 1'b1, "R9 done with last result", int'(done), 1);
            else             chk(done == 1'b0, "R9 done not early", int'(done), 0);
            @(negedge clk);
            chk(dout_vld == 1'b0, "R8 single-cycle valid", int'(dout_vld), 0);
        end
        rd_stb = 1'b1;
        @(negedge clk);
        rd_stb = 1'b0;
        chk(dout_vld == 1'b0, "R10 strobe after done ignored", int'(dout_vld), 0);
        chk(done == 1'b1, "R9 done held", int'(done), 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(done == 1'b0, "R1 done at reset", int'(done), 0);
        chk(dout_vld == 1'b0, "R1 valid at reset", int'(dout_vld), 0);
        chk(dout == '0, "R1 data at reset", int'(dout), 0);
        rd_stb = 1'b1;
        @(negedge clk);
        rd_stb = 1'b0;
        chk(dout_vld == 1'b0, "R10 strobe while idle ignored", int'(dout_vld), 0);

        // Pattern 1: spread ramp, first and last codes, never and held-high lanes.
        for (int i = 0; i < NS; i++) fire_at[i] = (i * 65) % (FULL + 1);
        fire_at[5] = -1;
        fire_at[6] = -2;
        run_conv(1'b1);
        rd_stb = 1'b1;
        @(negedge clk);
        rd_stb = 1'b0;
        chk(int'(dout) == 0, "R12 first strobe after conversion returns lane 0", int'(dout), 0);
        // Lane 1 (65) read next: gray(65)=97 must not appear, binary 65 must.
        rd_stb = 1'b1;
        @(negedge clk);
        rd_stb = 1'b0;
        chk(int'(dout) == 65, "R7 binary output", int'(dout), 65);
        for (int i = 2; i < NS; i++) begin
            int e;
            e = expect_of(fire_at[i]);
            rd_stb = 1'b1;
            @(negedge clk);
            rd_stb = 1'b0;
            chk(int'(dout) == e, "R3 ordered result", int'(dout), e);
            @(negedge clk);
        end
        chk(done == 1'b1, "R9 done after pattern 1", int'(done), 1);

        // Pattern 2: descending codes with some silent lanes, started from done.
        for (int i = 0; i < NS; i++) fire_at[i] = (i % 9 == 4) ? -1 : FULL - i * 61;
        run_conv(1'b0);
        read_all();

        // Pattern 3: aborted conversion, then a restart with a quadratic schedule.
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int c = 0; c < 30; c++) begin
            fire = (c >= 10) ? '1 : '0;
            @(negedge clk);
        end
        chk(done == 1'b0, "R11 done low mid conversion", int'(done), 0);
        for (int i = 0; i < NS; i++) fire_at[i] = (i * i * 37 + 11) % (FULL + 1);
        run_conv(1'b0);
        read_all();

        // Pattern 4: every lane fires in the same cycle.
        for (int i = 0; i < NS; i++) fire_at[i] = 2048;
        run_conv(1'b0);
        read_all();

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule